// File: doc/BRIEF.md
# SDRAM Bank Open-Row Tracker

This block sits between a request splitter and the transfer stage of an SDRAM controller. It accepts decoded requests that carry a bank, a row, a column, a direction and a close hint. For each bank it keeps track of whether a row is open and which row that is. It then emits the abstract command sequence that each request needs. If the row is already open, the read or write goes out at once. If another row is open, the bank is first precharged, then activated, then accessed. If the bank is idle, it is activated and then accessed.

Each bank has its own counters for the active-to-precharge, precharge-to-active and active-to-access intervals. Each interval is loaded from a 4-bit run-time setting. A small ordered queue holds pending requests to distinct banks. The number of held requests is capped by a run-time depth setting. The transfer stage returns permission flags and a refresh indication, and these gate every command the block issues.

Top module: `sdram_row_tracker`

## Requirements
- R1: After reset, `cmd_valid` is 0, every bank is treated as closed, and `req_ready` is 1.
- R2: A request whose row equals the open row of its bank produces a single access command (`cmd_kind` 2 = read, 3 = write), with the column zero-extended on `cmd_addr`. No precharge or activate comes before it.
- R3: A request to a closed bank produces an activate (`cmd_kind` 1) with the row on `cmd_addr`, followed by the access command.
- R4: A request to a bank that has a different row open produces a precharge (`cmd_kind` 0, `cmd_addr` 0), then an activate, then the access.
- R5: An access to a bank appears no sooner than `cfg_trcd`+1 cycles after that bank's activate.
- R6: A precharge to a bank appears no sooner than `cfg_tras`+1 cycles after that bank's activate.
- R7: An activate to a bank appears no sooner than `cfg_trp`+1 cycles after that bank's precharge.
- R8: After an access whose request had `req_close` set, the bank is precharged once its active interval allows. A later request to the same row then needs an activate again.
- R9: In the cycle after any cycle in which `xfer_refresh` is 1, `cmd_valid` is 0. After the refresh, every bank is treated as closed.
- R10: `req_ready` is 0 while the number of held requests equals `cfg_depth`+1.
- R11: `req_ready` is 0 while a held request targets the same bank as `req_bank`.
- R12: When several held requests can make progress in the same cycle, the command goes to the one that was accepted first. A pending close precharge is served before all of them.
- R13: No precharge to bank k is issued while `xfer_pre_ok[k]` is 0. No activate is issued while `xfer_act_ok` is 0. No read is issued while `xfer_rd_ok` is 0, and no write while `xfer_wr_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_depth | input | 2 | Held request limit minus one |
| cfg_tras | input | 4 | Active-to-precharge interval |
| cfg_trp | input | 4 | Precharge-to-active interval |
| cfg_trcd | input | 4 | Active-to-access interval |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 11 | Target column |
| req_write | input | 1 | 1 = write, 0 = read |
| req_close | input | 1 | Close the bank after this access |
| xfer_pre_ok | input | 4 | Per-bank precharge permission |
| xfer_act_ok | input | 1 | Activate permission |
| xfer_rd_ok | input | 1 | Read permission |
| xfer_wr_ok | input | 1 | Write permission |
| xfer_refresh | input | 1 | Refresh in progress |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_kind | output | 2 | 0 precharge, 1 activate, 2 read, 3 write |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | 13 | Row for activate, column for access |

## Verification
The bench measures the gaps between a bank's activate, precharge and access commands at their exact minimum values. A counter that loads one cycle late, or that releases a command one cycle early, therefore shows up as a wrong distance. It runs a miss while an access to the same row is still pending behind a stall, and a design that compared against a stale row would issue a stray access. It holds every permission flag low with two requests waiting, then releases them all at once, which catches both gating errors and a picker that serves the newest entry first. It sends a hit-looking request during a refresh, and a tracker that kept its open-row state through the refresh would emit a read with no activate.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic [1:0] {
        CMD_PRE   = 2'd0,
        CMD_ACT   = 2'd1,
        CMD_READ  = 2'd2,
        CMD_WRITE = 2'd3
    } cmd_kind_e;
endpackage

// File: rtl/rt_bank.sv
module rt_bank #(
    parameter int ROW_W = 13,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DLY_W-1:0] cfg_tras,
    input  logic [DLY_W-1:0] cfg_trp,
    input  logic [DLY_W-1:0] cfg_trcd,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_rw,
    input  logic             rw_close,
    input  logic             refresh,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic [ROW_W-1:0] open_row,
    output logic             pre_ready,
    output logic             act_ready,
    output logic             rw_ready,
    output logic             close_pend
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [DLY_W-1:0] tras;
        logic [DLY_W-1:0] trp;
        logic [DLY_W-1:0] trcd;
        logic             close;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.tras != '0) st_d.tras = st_q.tras - 1'b1;
        if (st_q.trp  != '0) st_d.trp  = st_q.trp  - 1'b1;
        if (st_q.trcd != '0) st_d.trcd = st_q.trcd - 1'b1;
        if (do_act) begin
            st_d.open = 1'b1;
            st_d.row  = act_row;
            st_d.tras = cfg_tras;
            st_d.trcd = cfg_trcd;
        end
        if (do_pre) begin
            st_d.open  = 1'b0;
            st_d.trp   = cfg_trp;
            st_d.close = 1'b0;
        end
        if (do_rw && rw_close) st_d.close = 1'b1;
        if (refresh) begin
            st_d.open  = 1'b0;
            st_d.close = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open    = st_q.open;
    assign open_row   = st_q.row;
    assign pre_ready  = st_q.open && (st_q.tras == '0);
    assign act_ready  = !st_q.open && (st_q.trp == '0);
    assign rw_ready   = st_q.open && (st_q.trcd == '0);
    assign close_pend = st_q.close;

    assert_trcd_met_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_rw |-> (st_q.open && st_q.trcd == '0));
    assert_tras_met_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> (st_q.open && st_q.tras == '0));
    assert_trp_met_R7: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (!st_q.open && st_q.trp == '0));
    assert_one_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({do_act, do_pre, do_rw}) <= 1);
endmodule

// File: rtl/rt_queue.sv
module rt_queue #(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    localparam int BANK_W = $clog2(NB),
    localparam int CNT_W  = $clog2(NB + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [BANK_W-1:0]           push_bank,
    input  logic [ROW_W-1:0]            push_row,
    input  logic [COL_W-1:0]            push_col,
    input  logic                        push_wr,
    input  logic                        push_close,
    input  logic                        pop,
    input  logic [BANK_W-1:0]           pop_idx,
    output logic [NB-1:0]               q_vld,
    output logic [NB-1:0][BANK_W-1:0]   q_bank,
    output logic [NB-1:0][ROW_W-1:0]    q_row,
    output logic [NB-1:0][COL_W-1:0]    q_col,
    output logic [NB-1:0]               q_wr,
    output logic [NB-1:0]               q_close,
    output logic [CNT_W-1:0]            q_count
);
    typedef struct packed {
        logic [NB-1:0]             vld;
        logic [NB-1:0][BANK_W-1:0] bank;
        logic [NB-1:0][ROW_W-1:0]  row;
        logic [NB-1:0][COL_W-1:0]  col;
        logic [NB-1:0]             wr;
        logic [NB-1:0]             close;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [CNT_W-1:0] slot;

    assign q_count = CNT_W'($countones(st_q.vld));

    always_comb begin
        st_d = st_q;
        slot = q_count;
        if (pop) begin
            for (int i = 0; i < NB - 1; i++) begin
                if (i >= int'(pop_idx)) begin
                    st_d.vld[i]   = st_q.vld[i+1];
                    st_d.bank[i]  = st_q.bank[i+1];
                    st_d.row[i]   = st_q.row[i+1];
                    st_d.col[i]   = st_q.col[i+1];
                    st_d.wr[i]    = st_q.wr[i+1];
                    st_d.close[i] = st_q.close[i+1];
                end
            end
            st_d.vld[NB-1] = 1'b0;
            slot = q_count - 1'b1;
        end
        if (push) begin
            for (int i = 0; i < NB; i++) begin
                if (i == int'(slot)) begin
                    st_d.vld[i]   = 1'b1;
                    st_d.bank[i]  = push_bank;
                    st_d.row[i]   = push_row;
                    st_d.col[i]   = push_col;
                    st_d.wr[i]    = push_wr;
                    st_d.close[i] = push_close;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_vld   = st_q.vld;
    assign q_bank  = st_q.bank;
    assign q_row   = st_q.row;
    assign q_col   = st_q.col;
    assign q_wr    = st_q.wr;
    assign q_close = st_q.close;

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(q_count) < NB || pop));
    assert_pop_live_R12: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.vld[pop_idx]);
    assert_compact_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.vld & (st_q.vld + 1'b1)) == '0));
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
    parameter int NB    = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 11,
    parameter int DLY_W = 4,
    localparam int BANK_W = $clog2(NB),
    localparam int CNT_W  = $clog2(NB + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] cfg_depth,
    input  logic [DLY_W-1:0]  cfg_tras,
    input  logic [DLY_W-1:0]  cfg_trp,
    input  logic [DLY_W-1:0]  cfg_trcd,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_write,
    input  logic              req_close,
    input  logic [NB-1:0]     xfer_pre_ok,
    input  logic              xfer_act_ok,
    input  logic              xfer_rd_ok,
    input  logic              xfer_wr_ok,
    input  logic              xfer_refresh,
    output logic              cmd_valid,
    output logic [1:0]        cmd_kind,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr
);
    import rt_pkg::*;

    typedef struct packed {
        logic              vld;
        cmd_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  addr;
    } cmd_st_t;

    cmd_st_t cmd_d, cmd_q;

    logic [NB-1:0]             q_vld, q_wr, q_close;
    logic [NB-1:0][BANK_W-1:0] q_bank;
    logic [NB-1:0][ROW_W-1:0]  q_row;
    logic [NB-1:0][COL_W-1:0]  q_col;
    logic [CNT_W-1:0]          q_count;

    logic [NB-1:0]            bk_open, bk_pre_rdy, bk_act_rdy, bk_rw_rdy, bk_close;
    logic [NB-1:0][ROW_W-1:0] bk_row;
    logic [NB-1:0]            do_act, do_pre, do_rw, rw_close;
    logic [ROW_W-1:0]         sel_row;
    logic                     pop, push, same_bank;
    logic [BANK_W-1:0]        pop_idx;

    always_comb begin
        same_bank = 1'b0;
        for (int i = 0; i < NB; i++)
            if (q_vld[i] && q_bank[i] == req_bank) same_bank = 1'b1;
    end
    assign req_ready = (int'(q_count) <= int'(cfg_depth)) && !same_bank;
    assign push      = req_valid && req_ready;

    always_comb begin
        logic              found;
        logic [BANK_W-1:0] b;
        found    = 1'b0;
        b        = '0;
        cmd_d    = '0;
        do_act   = '0;
        do_pre   = '0;
        do_rw    = '0;
        rw_close = '0;
        sel_row  = '0;
        pop      = 1'b0;
        pop_idx  = '0;
        if (!xfer_refresh) begin
            for (int k = 0; k < NB; k++) begin
                if (!found && bk_close[k] && bk_pre_rdy[k] && xfer_pre_ok[k]) begin
                    found     = 1'b1;
                    do_pre[k] = 1'b1;
                    cmd_d.vld = 1'b1;
                    cmd_d.kind = CMD_PRE;
                    cmd_d.bank = BANK_W'(k);
                end
            end
            for (int i = 0; i < NB; i++) begin
                if (!found && q_vld[i]) begin
                    b = q_bank[i];
                    if (bk_open[b] && bk_row[b] == q_row[i]) begin
                        if (bk_rw_rdy[b] && (q_wr[i] ? xfer_wr_ok : xfer_rd_ok)) begin
                            found       = 1'b1;
                            do_rw[b]    = 1'b1;
                            rw_close[b] = q_close[i];
                            pop         = 1'b1;
                            pop_idx     = BANK_W'(i);
                            cmd_d.vld   = 1'b1;
                            cmd_d.kind  = q_wr[i] ? CMD_WRITE : CMD_READ;
                            cmd_d.bank  = b;
                            cmd_d.addr  = ROW_W'(q_col[i]);
                        end
                    end else if (bk_open[b]) begin
                        if (bk_pre_rdy[b] && xfer_pre_ok[b]) begin
                            found      = 1'b1;
                            do_pre[b]  = 1'b1;
                            cmd_d.vld  = 1'b1;
                            cmd_d.kind = CMD_PRE;
                            cmd_d.bank = b;
                        end
                    end else if (bk_act_rdy[b] && xfer_act_ok) begin
                        found      = 1'b1;
                        do_act[b]  = 1'b1;
                        sel_row    = q_row[i];
                        cmd_d.vld  = 1'b1;
                        cmd_d.kind = CMD_ACT;
                        cmd_d.bank = b;
                        cmd_d.addr = q_row[i];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign cmd_valid = cmd_q.vld;
    assign cmd_kind  = cmd_q.kind;
    assign cmd_bank  = cmd_q.bank;
    assign cmd_addr  = cmd_q.addr;

    rt_queue #(.NB(NB), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_bank(req_bank), .push_row(req_row), .push_col(req_col),
        .push_wr(req_write), .push_close(req_close),
        .pop(pop), .pop_idx(pop_idx),
        .q_vld(q_vld), .q_bank(q_bank), .q_row(q_row), .q_col(q_col),
        .q_wr(q_wr), .q_close(q_close), .q_count(q_count)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        rt_bank #(.ROW_W(ROW_W), .DLY_W(DLY_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
            .do_act(do_act[g]), .do_pre(do_pre[g]), .do_rw(do_rw[g]),
            .rw_close(rw_close[g]), .refresh(xfer_refresh), .act_row(sel_row),
            .is_open(bk_open[g]), .open_row(bk_row[g]),
            .pre_ready(bk_pre_rdy[g]), .act_ready(bk_act_rdy[g]),
            .rw_ready(bk_rw_rdy[g]), .close_pend(bk_close[g])
        );
    end

    assert_refresh_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_refresh |=> !cmd_valid);
    assert_act_gated_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_d.vld && cmd_d.kind == CMD_ACT) |-> xfer_act_ok);
endmodule

// File: tb/sdram_row_tracker_bench.sv
module sdram_row_tracker_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'd3;
    logic [3:0]  cfg_tras = 4'd5, cfg_trp = 4'd2, cfg_trcd = 4'd3;
    logic        req_valid = 1'b0, req_write = 1'b0, req_close = 1'b0;
    logic        req_ready;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [10:0] req_col = '0;
    logic [3:0]  xfer_pre_ok = 4'hF;
    logic        xfer_act_ok = 1'b1, xfer_rd_ok = 1'b1, xfer_wr_ok = 1'b1, xfer_refresh = 1'b0;
    logic        cmd_valid;
    logic [1:0]  cmd_kind, cmd_bank;
    logic [12:0] cmd_addr;

    int tests = 0, fails = 0, cyc = 0, log_n = 0;
    int lk[64], lb[64], la[64], lc[64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_row_tracker u_sdram_row_tracker (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_row(req_row), .req_col(req_col), .req_write(req_write), .req_close(req_close),
        .xfer_pre_ok(xfer_pre_ok), .xfer_act_ok(xfer_act_ok), .xfer_rd_ok(xfer_rd_ok),
        .xfer_wr_ok(xfer_wr_ok), .xfer_refresh(xfer_refresh),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
    );

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n && cmd_valid && log_n < 64) begin
            lk[log_n] = int'(cmd_kind);
            lb[log_n] = int'(cmd_bank);
            la[log_n] = int'(cmd_addr);
            lc[log_n] = cyc;
            log_n = log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_cmd(input int idx, input int kind, input int bank, input int addr, input string tag);
        int a, e;
        e = kind * 100000 + bank * 10000 + addr;
        a = (idx < log_n) ? lk[idx] * 100000 + lb[idx] * 10000 + la[idx] : -1;
        chk(a == e, tag, a, e);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic issue(input int bank, input int row, input int col, input bit wr, input bit cls);
        @(negedge clk);
        req_valid = 1'b1; req_bank = 2'(bank); req_row = 13'(row);
        req_col = 11'(col); req_write = wr; req_close = cls;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0; req_close = 1'b0;
    endtask

    task automatic t_reset;
        chk(cmd_valid == 1'b0, "R1 cmd_valid idle", int'(cmd_valid), 0);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_closed_bank;
        int base = log_n;
        issue(0, 10, 4, 1'b0, 1'b0);
        run(12);
        expect_cmd(base, 1, 0, 10, "R3 activate closed bank");
        expect_cmd(base + 1, 2, 0, 4, "R3 read after activate");
        chk(lc[base + 1] - lc[base] == 4, "R5 trcd gap", lc[base + 1] - lc[base], 4);
    endtask

    task automatic t_hit;
        int base = log_n;
        issue(0, 10, 5, 1'b1, 1'b0);
        run(6);
        chk(log_n - base == 1, "R2 single command on hit", log_n - base, 1);
        expect_cmd(base, 3, 0, 5, "R2 write on hit");
    endtask

    task automatic t_miss;
        int base = log_n;
        issue(0, 20, 1, 1'b0, 1'b0);
        run(20);
        expect_cmd(base, 0, 0, 0, "R4 precharge first");
        expect_cmd(base + 1, 1, 0, 20, "R4 activate new row");
        expect_cmd(base + 2, 2, 0, 1, "R4 read last");
        chk(lc[base + 1] - lc[base] == 3, "R7 trp gap", lc[base + 1] - lc[base], 3);
    endtask

    task automatic t_tras;
        int base;
        cfg_tras = 4'd9;
        base = log_n;
        issue(1, 3, 0, 1'b0, 1'b0);
        issue(1, 4, 0, 1'b0, 1'b0);
        run(30);
        expect_cmd(base + 2, 0, 1, 0, "R6 precharge on miss");
        chk(lc[base + 2] - lc[base] == 10, "R6 tras gap", lc[base + 2] - lc[base], 10);
        expect_cmd(base + 4, 2, 1, 0, "R4 second read");
    endtask

    task automatic t_close;
        int base = log_n;
        issue(3, 7, 2, 1'b0, 1'b1);
        run(25);
        expect_cmd(base + 2, 0, 3, 0, "R8 close precharge");
        base = log_n;
        issue(3, 7, 3, 1'b0, 1'b0);
        run(12);
        expect_cmd(base, 1, 3, 7, "R8 reopen after close");
    endtask

    task automatic t_order_gate;
        int base;
        xfer_pre_ok = 4'h0; xfer_act_ok = 1'b0; xfer_rd_ok = 1'b0; xfer_wr_ok = 1'b0;
        base = log_n;
        issue(3, 1, 0, 1'b0, 1'b0);
        issue(2, 1, 0, 1'b0, 1'b0);
        run(5);
        chk(log_n == base, "R13 no command while gated", log_n - base, 0);
        xfer_pre_ok = 4'hF; xfer_act_ok = 1'b1; xfer_rd_ok = 1'b1; xfer_wr_ok = 1'b1;
        run(20);
        expect_cmd(base, 0, 3, 0, "R12 oldest served first");
    endtask

    task automatic t_depth_stall;
        xfer_pre_ok = 4'h0; xfer_act_ok = 1'b0;
        cfg_depth = 2'd1;
        issue(0, 99, 0, 1'b0, 1'b0);
        issue(2, 99, 0, 1'b0, 1'b0);
        req_bank = 2'd1; #1;
        chk(req_ready == 1'b0, "R10 full at depth", int'(req_ready), 0);
        cfg_depth = 2'd3; #1;
        chk(req_ready == 1'b1, "R10 room after depth raise", int'(req_ready), 1);
        req_bank = 2'd0; #1;
        chk(req_ready == 1'b0, "R11 same bank stall", int'(req_ready), 0);
        xfer_pre_ok = 4'hF; xfer_act_ok = 1'b1;
        run(40);
    endtask

    task automatic t_refresh;
        int base;
        xfer_refresh = 1'b1;
        base = log_n;
        issue(1, 4, 6, 1'b0, 1'b0);
        run(4);
        chk(log_n == base, "R9 quiet during refresh", log_n - base, 0);
        xfer_refresh = 1'b0;
        run(12);
        expect_cmd(base, 1, 1, 4, "R9 banks closed by refresh");
    endtask

    initial begin
        run(3);
        rst_n = 1'b1;
        run(2);
        t_reset();
        t_closed_bank();
        t_hit();
        t_miss();
        t_tras();
        t_close();
        t_order_gate();
        t_depth_stall();
        t_refresh();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule